// File: doc/BRIEF.md
# Response Check and Retry Sequencer

This block sits between a serial-link frame sender and the logic that issues read and write transactions to a remote slave. Each transaction starts with a size request. The sequencer then asks the frame sender to transmit the command frame and accepts the raw reply. The reply holds a 4-bit tag, up to 32 right-aligned data bits and a 4-bit check code. The block checks the CRC residue of the reply and decodes the acknowledge code. It then runs the recovery sequence without outside help. Busy replies lead to idle-clock bursts followed by data-polls. Corrupted replies lead to idle-clock bursts followed by error-polls. A slave that stays busy is terminated. A recoverable error restarts the whole command.

All three data-carrying edges use valid/ready. The command edge accepts a new transaction only while the block is free. Outgoing requests to the frame sender are held stable, kind and count together, until `req_ready` is seen. A request is withdrawn only when the watchdog expires. The sender may stall for any number of cycles. Replies are taken only while `rsp_ready` is high, and `rsp_valid` may be held off for as long as the sender needs. Each transaction ends with a single-cycle `done` and exactly one status flag. On success, `rd_data` carries the returned word.

Top module: `rcs_resp_seq`

## Requirements
- R1: The acknowledge code is the low two bits of the reply tag: 0 = ACK, 1 = BUSY, 2 = hard error, 3 = soft error. The upper two tag bits do not affect decoding.
- R2: The reply is valid when a 4-bit CRC register reaches zero. The register starts at 0, uses generator x^4+x^2+x+1, and is fed most-significant bit first with: a single 1 bit, the 4 tag bits, the low 8/16/32 data bits (only when the code is ACK and the size is nonzero), and the 4 received check bits. Data bits above the requested width are not fed.
- R3: A failed check where tag and check bits are both 4'hF or both 4'h0 ends the transaction with `no_dev` and no retry.
- R4: Any other failed check is followed by an idle burst of CRC_IDLE clocks and then an error-poll, and the new reply is evaluated. The next failed check after CRC_RETRIES error-polls within one command attempt ends with `io_err`.
- R5: A BUSY reply is followed by an idle burst of BUSY_IDLE clocks (at least 21). After that comes a data-poll, for at most BUSY_MAX data-polls per attempt. A further BUSY gets the idle burst and then a terminate request; once its reply arrives, the transaction ends with `io_err`, whatever the reply holds.
- R6: A hard-error reply ends the transaction with `io_err`.
- R7: A soft-error reply resends the command, with fresh poll counters, up to CMD_TRIES attempts in total. A soft error on the last attempt ends with `io_err`.
- R8: An idle burst of N clocks is issued as consecutive idle requests (`req_kind` 1) whose `req_count` is 255 for each full chunk and the remainder last. The counts sum to N, and no request carries 0.
- R9: On ACK the block ends with `ok`. `rd_data` holds the low 8, 16 or 32 data bits for `cmd_size` 1, 2 or 3, zero-extended, and holds 0 for size 0.
- R10: `done` lasts one cycle, and exactly one of `ok`, `no_dev`, `io_err`, `timeout` is high with it. All four are low when `done` is low.
- R11: If a request is not accepted, or a reply not presented, within WD_LIMIT cycles of waiting, the transaction ends with `timeout`.
- R12: Request kinds are command 0, idle 1, data-poll 2, error-poll 3 and terminate 4, and `req_count` is 0 for non-idle kinds. `cmd_ready` is high only while no transaction runs. `req_valid` and `rsp_ready` are never high together. After reset, the block is free and all handshake outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | New transaction request |
| cmd_ready | output | 1 | Block is free to accept a transaction |
| cmd_size | input | 2 | Reply data size: 0 none, 1 byte, 2 half-word, 3 word |
| req_valid | output | 1 | Request to the frame sender pending |
| req_ready | input | 1 | Frame sender accepts the request |
| req_kind | output | 3 | Request kind code |
| req_count | output | 8 | Idle clock count for idle requests |
| rsp_valid | input | 1 | Raw reply present |
| rsp_ready | output | 1 | Block is waiting for a reply |
| rsp_tag | input | 4 | Reply tag |
| rsp_data | input | 32 | Reply data, right-aligned |
| rsp_crc | input | 4 | Received check bits |
| done | output | 1 | Transaction finished (one cycle) |
| ok | output | 1 | Success status |
| no_dev | output | 1 | Link dead status |
| io_err | output | 1 | I/O error status |
| timeout | output | 1 | Watchdog status |
| rd_data | output | 32 | Returned data |

## Verification
The bench targets the limit edges of each retry counter. It checks a CRC failure on the last allowed error-poll and a busy reply one past the data-poll limit; an off-by-one design would issue an extra poll or terminate one poll early. It checks the data residue with upper data bits set and with a zero size, where a design feeding the whole word into the CRC would reject a good reply. It checks the 300-clock burst split, where a design without the split would emit a wrapped count. It checks a stalled sender, where a missing or mis-sized watchdog would hang the run or end it at the wrong cycle.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [2:0] {
    K_CMD   = 3'd0,
    K_IDLE  = 3'd1,
    K_DPOLL = 3'd2,
    K_EPOLL = 3'd3,
    K_TERM  = 3'd4
  } req_kind_e;

  typedef enum logic [1:0] {
    A_ACK  = 2'd0,
    A_BUSY = 2'd1,
    A_HARD = 2'd2,
    A_SOFT = 2'd3
  } ack_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_RSP  = 2'd2,
    S_EVAL = 2'd3
  } seq_st_e;

  localparam int CHUNK_MAX = 255;

  // status vector bits: {timeout, io_err, no_dev, ok}
  localparam logic [3:0] ST_OK  = 4'b0001;
  localparam logic [3:0] ST_NOD = 4'b0010;
  localparam logic [3:0] ST_IO  = 4'b0100;
  localparam logic [3:0] ST_TMO = 4'b1000;

  function automatic int size_bits(input logic [1:0] sz);
    case (sz)
      2'd1:    return 8;
      2'd2:    return 16;
      2'd3:    return 32;
      default: return 0;
    endcase
  endfunction

  // serial CRC step over the low n bits of v, msb first
  function automatic logic [3:0] crc4_feed(input logic [3:0] c_in,
                                           input logic [31:0] v,
                                           input int n);
    logic [3:0] c;
    logic fb;
    c = c_in;
    for (int i = 31; i >= 0; i--) begin
      if (i < n) begin
        fb = c[3] ^ v[i];
        c  = {c[2:0], 1'b0} ^ (fb ? 4'h7 : 4'h0);
      end
    end
    return c;
  endfunction

  function automatic logic [31:0] mask_data(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      2'd1:    return {24'd0, d[7:0]};
      2'd2:    return {16'd0, d[15:0]};
      2'd3:    return d;
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/rcs_rsp_check.sv
module rcs_rsp_check
  import rcs_pkg::*;
(
  input  logic [3:0]  tag,
  input  logic [31:0] data,
  input  logic [3:0]  crc,
  input  logic [1:0]  size,
  output ack_e        code,
  output logic        crc_ok,
  output logic        dead
);
  logic [3:0] res;

  always_comb begin
    code = ack_e'(tag[1:0]);
    res  = crc4_feed(4'h0, 32'h1, 1);
    res  = crc4_feed(res, {28'd0, tag}, 4);
    if (tag[1:0] == A_ACK)
      res = crc4_feed(res, data, size_bits(size));
    res    = crc4_feed(res, {28'd0, crc}, 4);
    crc_ok = (res == 4'h0);
    dead   = ((tag == 4'hF) && (crc == 4'hF)) || ((tag == 4'h0) && (crc == 4'h0));
  end
endmodule

// File: rtl/rcs_burst_split.sv
module rcs_burst_split
  import rcs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             take,
  output logic [7:0]       chunk,
  output logic             last
);
  logic [CNT_W-1:0] rem_q;

  always_comb begin
    last  = (rem_q <= CNT_W'(CHUNK_MAX));
    chunk = last ? rem_q[7:0] : 8'(CHUNK_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (take) rem_q <= rem_q - CNT_W'(chunk);
  end
endmodule

// File: rtl/rcs_wdog.sv
module rcs_wdog #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic kick,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  assign expired = active && !kick && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!active || kick)  cnt_q <= '0;
    else if (!expired)         cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/rcs_resp_seq.sv
module rcs_resp_seq
  import rcs_pkg::*;
#(
  parameter int CRC_RETRIES = 2,
  parameter int BUSY_MAX    = 3,
  parameter int CMD_TRIES   = 3,
  parameter int BUSY_IDLE   = 21,
  parameter int CRC_IDLE    = 300,
  parameter int WD_LIMIT    = 64,
  parameter int CNT_W       = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_size,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [2:0]  req_kind,
  output logic [7:0]  req_count,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [3:0]  rsp_tag,
  input  logic [31:0] rsp_data,
  input  logic [3:0]  rsp_crc,
  output logic        done,
  output logic        ok,
  output logic        no_dev,
  output logic        io_err,
  output logic        timeout,
  output logic [31:0] rd_data
);
  localparam int CRCN_W = $clog2(CRC_RETRIES + 2);
  localparam int BSYN_W = $clog2(BUSY_MAX + 2);
  localparam int TRY_W  = $clog2(CMD_TRIES + 2);

  seq_st_e           state_q;
  req_kind_e         kind_q, pend_q;
  logic [1:0]        size_q;
  logic [CRCN_W-1:0] crcn_q;
  logic [BSYN_W-1:0] busyn_q;
  logic [TRY_W-1:0]  tries_q;
  logic [3:0]        tag_q, crc_q, stat_q;
  logic [31:0]       data_q, rdata_q;
  logic              done_q;

  ack_e        code;
  logic        crc_ok, dead;
  logic [7:0]  chunk;
  logic        chunk_last, wd_exp, wd_active, wd_kick;
  logic        in_eval, go_epoll, go_busy, split_load, split_take;
  logic [CNT_W-1:0] split_val;

  rcs_rsp_check u_check (
    .tag(tag_q), .data(data_q), .crc(crc_q), .size(size_q),
    .code(code), .crc_ok(crc_ok), .dead(dead)
  );

  always_comb begin
    in_eval    = (state_q == S_EVAL);
    go_epoll   = in_eval && (kind_q != K_TERM) && !crc_ok && !dead &&
                 (crcn_q < CRCN_W'(CRC_RETRIES));
    go_busy    = in_eval && (kind_q != K_TERM) && crc_ok && (code == A_BUSY);
    split_load = go_epoll || go_busy;
    split_val  = go_busy ? CNT_W'(BUSY_IDLE) : CNT_W'(CRC_IDLE);
    split_take = (state_q == S_REQ) && req_ready && (kind_q == K_IDLE) && !wd_exp;
    wd_active  = (state_q == S_REQ) || (state_q == S_RSP);
    wd_kick    = ((state_q == S_REQ) && req_ready) || ((state_q == S_RSP) && rsp_valid);
  end

  rcs_burst_split #(.CNT_W(CNT_W)) u_split (
    .clk(clk), .rst_n(rst_n), .load(split_load), .load_val(split_val),
    .take(split_take), .chunk(chunk), .last(chunk_last)
  );

  rcs_wdog #(.LIMIT(WD_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .active(wd_active), .kick(wd_kick), .expired(wd_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_CMD;
      pend_q  <= K_CMD;
      size_q  <= '0;
      crcn_q  <= '0;
      busyn_q <= '0;
      tries_q <= '0;
      tag_q   <= '0;
      crc_q   <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      stat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      stat_q <= '0;
      case (state_q)
        S_IDLE: if (cmd_valid) begin
          size_q  <= cmd_size;
          tries_q <= TRY_W'(1);
          crcn_q  <= '0;
          busyn_q <= '0;
          kind_q  <= K_CMD;
          state_q <= S_REQ;
        end
        S_REQ: begin
          if (wd_exp) begin
            stat_q <= ST_TMO; done_q <= 1'b1; state_q <= S_IDLE;
          end else if (req_ready) begin
            if (kind_q == K_IDLE) begin
              if (chunk_last) kind_q <= pend_q;
            end else begin
              state_q <= S_RSP;
            end
          end
        end
        S_RSP: begin
          if (wd_exp) begin
            stat_q <= ST_TMO; done_q <= 1'b1; state_q <= S_IDLE;
          end else if (rsp_valid) begin
            tag_q   <= rsp_tag;
            data_q  <= rsp_data;
            crc_q   <= rsp_crc;
            state_q <= S_EVAL;
          end
        end
        S_EVAL: begin
          state_q <= S_IDLE;
          if (kind_q == K_TERM) begin
            stat_q <= ST_IO; done_q <= 1'b1;
          end else if (!crc_ok) begin
            if (dead) begin
              stat_q <= ST_NOD; done_q <= 1'b1;
            end else if (go_epoll) begin
              crcn_q  <= crcn_q + CRCN_W'(1);
              pend_q  <= K_EPOLL;
              kind_q  <= K_IDLE;
              state_q <= S_REQ;
            end else begin
              stat_q <= ST_IO; done_q <= 1'b1;
            end
          end else begin
            case (code)
              A_ACK: begin
                stat_q  <= ST_OK; done_q <= 1'b1;
                rdata_q <= mask_data(data_q, size_q);
              end
              A_BUSY: begin
                if (busyn_q < BSYN_W'(BUSY_MAX)) begin
                  busyn_q <= busyn_q + BSYN_W'(1);
                  pend_q  <= K_DPOLL;
                end else begin
                  pend_q  <= K_TERM;
                end
                kind_q  <= K_IDLE;
                state_q <= S_REQ;
              end
              A_SOFT: begin
                if (tries_q < TRY_W'(CMD_TRIES)) begin
                  tries_q <= tries_q + TRY_W'(1);
                  crcn_q  <= '0;
                  busyn_q <= '0;
                  kind_q  <= K_CMD;
                  state_q <= S_REQ;
                end else begin
                  stat_q <= ST_IO; done_q <= 1'b1;
                end
              end
              default: begin
                stat_q <= ST_IO; done_q <= 1'b1;
              end
            endcase
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign req_valid = (state_q == S_REQ);
  assign req_kind  = kind_q;
  assign req_count = (kind_q == K_IDLE) ? chunk : 8'd0;
  assign rsp_ready = (state_q == S_RSP);
  assign done      = done_q;
  assign ok        = stat_q[0];
  assign no_dev    = stat_q[1];
  assign io_err    = stat_q[2];
  assign timeout   = stat_q[3];
  assign rd_data   = rdata_q;

endmodule

// File: rtl/rcs_resp_seq_chk.sv
module rcs_resp_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_size,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_kind,
  input logic [7:0]  req_count,
  input logic        rsp_ready,
  input logic        done,
  input logic        ok,
  input logic        no_dev,
  input logic        io_err,
  input logic        timeout,
  input logic [31:0] rd_data
);
  logic [1:0] sz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sz_q <= '0;
    else if (cmd_valid && cmd_ready) sz_q <= cmd_size;
  end

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({ok, no_dev, io_err, timeout}));
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(ok || no_dev || io_err || timeout));
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_nonzero_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd1) |-> req_count != 8'd0);
  a_r12_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 3'd1) |-> req_count == 8'd0);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      ((req_valid && $stable(req_kind) && $stable(req_count)) || done));
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready) && !(cmd_ready && (req_valid || rsp_ready)));
  a_r9_width: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> ((sz_q == 2'd0 && rd_data == 32'd0) ||
                      (sz_q == 2'd1 && rd_data[31:8] == 24'd0) ||
                      (sz_q == 2'd2 && rd_data[31:16] == 16'd0) ||
                      (sz_q == 2'd3)));
  a_r11_tmo_source: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(req_valid || rsp_ready));
endmodule

bind rcs_resp_seq rcs_resp_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_size(cmd_size), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_count(req_count), .rsp_ready(rsp_ready),
  .done(done), .ok(ok), .no_dev(no_dev), .io_err(io_err),
  .timeout(timeout), .rd_data(rd_data)
);

// File: tb/tb_rcs_resp_seq.sv
module tb_rcs_resp_seq;
  localparam int CLK_PERIOD  = 10;
  localparam int CRC_RETRIES = 2;
  localparam int BUSY_MAX    = 3;
  localparam int CMD_TRIES   = 3;
  localparam int BUSY_IDLE   = 21;
  localparam int CRC_IDLE    = 300;
  localparam int WD_LIMIT    = 64;
  localparam int SCN         = 32;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, req_ready = 0, rsp_valid = 0;
  logic [1:0] cmd_size = 0;
  logic [3:0] rsp_tag = 0, rsp_crc = 0;
  logic [31:0] rsp_data = 0;
  logic cmd_ready, req_valid, rsp_ready, done, ok, no_dev, io_err, timeout;
  logic [2:0] req_kind;
  logic [7:0] req_count;
  logic [31:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcs_resp_seq #(.CRC_RETRIES(CRC_RETRIES), .BUSY_MAX(BUSY_MAX), .CMD_TRIES(CMD_TRIES),
                 .BUSY_IDLE(BUSY_IDLE), .CRC_IDLE(CRC_IDLE), .WD_LIMIT(WD_LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_size(cmd_size), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_count(req_count), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rsp_crc(rsp_crc),
    .done(done), .ok(ok), .no_dev(no_dev), .io_err(io_err), .timeout(timeout),
    .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  logic [3:0]  sc_tag [SCN];
  logic [31:0] sc_data[SCN];
  logic [3:0]  sc_crc [SCN];
  int exp_log[64], obs_log[64];
  int exp_n, obs_n;
  logic [3:0] exp_stat;
  logic [31:0] exp_data;

  task automatic chk(input bit c, input string rq, input longint act, input longint exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] sz);
    return (sz == 0) ? 0 : (4 << sz);
  endfunction

  function automatic logic [3:0] crc_run(input logic [3:0] c0, input logic [31:0] v, input int n);
    logic [3:0] c = c0;
    for (int i = n - 1; i >= 0; i--) begin
      if ((c[3] ^ v[i]) == 1'b1) c = {c[2:0], 1'b0} ^ 4'b0111;
      else c = {c[2:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [3:0] frame_crc(input logic [3:0] tg, input logic [31:0] d, input logic [1:0] sz);
    logic [3:0] c;
    c = crc_run(4'h0, 32'h1, 1);
    c = crc_run(c, {28'd0, tg}, 4);
    if (tg[1:0] == 2'd0) c = crc_run(c, d, wbits(sz));
    return c;
  endfunction

  function automatic bit frame_good(input logic [3:0] tg, input logic [31:0] d,
                                    input logic [3:0] cr, input logic [1:0] sz);
    return crc_run(frame_crc(tg, d, sz), {28'd0, cr}, 4) == 4'h0;
  endfunction

  // mode: 0 good, 1 corrupt, 2 all ones, 3 all zeros
  task automatic set_rsp(input int i, input logic [3:0] tg, input logic [31:0] d,
                         input int mode, input logic [1:0] sz);
    sc_data[i] = d;
    case (mode)
      0: begin sc_tag[i] = tg; sc_crc[i] = frame_crc(tg, d, sz); end
      1: begin sc_tag[i] = tg; sc_crc[i] = frame_crc(tg, d, sz) ^ 4'($urandom_range(15, 1)); end
      2: begin sc_tag[i] = 4'hF; sc_crc[i] = 4'hF; end
      default: begin sc_tag[i] = 4'h0; sc_crc[i] = 4'h0; end
    endcase
  endtask

  task automatic push(input int k, input int c);
    if (exp_n < 64) exp_log[exp_n] = k * 256 + c;
    exp_n++;
  endtask

  task automatic push_idle(input int total);
    int t = total;
    while (t > 0) begin
      push(1, (t > 255) ? 255 : t);
      t -= (t > 255) ? 255 : t;
    end
  endtask

  task automatic model(input logic [1:0] sz);
    int p = 0, tries = 1, crcn = 0, busyn = 0;
    bit fin = 0;
    exp_n = 0; exp_data = 0;
    push(0, 0);
    while (!fin && p < SCN) begin
      logic [3:0] tg = sc_tag[p];
      logic [3:0] cr = sc_crc[p];
      logic [31:0] d = sc_data[p];
      p++;
      if (!frame_good(tg, d, cr, sz)) begin
        if ((tg == 4'hF && cr == 4'hF) || (tg == 4'h0 && cr == 4'h0)) begin exp_stat = 4'b0010; fin = 1; end
        else if (crcn >= CRC_RETRIES) begin exp_stat = 4'b0100; fin = 1; end
        else begin crcn++; push_idle(CRC_IDLE); push(3, 0); end
      end else begin
        case (tg[1:0])
          2'd0: begin
            exp_stat = 4'b0001; fin = 1;
            exp_data = (sz == 0) ? 32'd0 : (sz == 3) ? d : (d & ((32'd1 << wbits(sz)) - 1));
          end
          2'd1: begin
            push_idle(BUSY_IDLE);
            if (busyn < BUSY_MAX) begin busyn++; push(2, 0); end
            else begin push(4, 0); p++; exp_stat = 4'b0100; fin = 1; end
          end
          2'd2: begin exp_stat = 4'b0100; fin = 1; end
          default: begin
            if (tries < CMD_TRIES) begin tries++; crcn = 0; busyn = 0; push(0, 0); end
            else begin exp_stat = 4'b0100; fin = 1; end
          end
        endcase
      end
    end
  endtask

  task automatic run_txn(input logic [1:0] sz, input bit stall, input string rq);
    int p = 0, vcnt = 0;
    bit got = 0;
    logic [3:0] st = 0;
    logic [31:0] rd = 0;
    if (!stall) model(sz);
    else begin exp_n = 0; exp_stat = 4'b1000; exp_data = 0; end
    obs_n = 0;
    @(negedge clk);
    chk(cmd_ready, {rq, " R12 ready when free"}, cmd_ready, 1);
    cmd_valid = 1; cmd_size = sz;
    @(negedge clk);
    cmd_valid = 0;
    for (int cyc = 0; cyc < 4000 && !got; cyc++) begin
      if (done) begin
        got = 1; st = {timeout, io_err, no_dev, ok}; rd = rd_data;
        req_ready = 0; rsp_valid = 0;
      end else begin
        if (req_valid) vcnt++;
        req_ready = req_valid && !stall && ($urandom_range(3) != 0);
        if (req_ready) begin
          if (obs_n < 64) obs_log[obs_n] = int'(req_kind) * 256 + int'(req_count);
          obs_n++;
        end
        rsp_valid = rsp_ready && ($urandom_range(2) != 0);
        if (rsp_valid) begin
          rsp_tag = sc_tag[p % SCN]; rsp_data = sc_data[p % SCN]; rsp_crc = sc_crc[p % SCN];
          p++;
        end
        @(negedge clk);
      end
    end
    chk(got, {rq, " done seen"}, got, 1);
    chk(st == exp_stat, {rq, " status"}, st, exp_stat);
    if (exp_stat == 4'b0001) chk(rd == exp_data, {rq, " R9 data"}, rd, exp_data);
    chk(obs_n == exp_n, {rq, " request count"}, obs_n, exp_n);
    for (int i = 0; i < obs_n && i < exp_n && i < 64; i++)
      chk(obs_log[i] == exp_log[i], {rq, " R8 R12 request sequence"}, obs_log[i], exp_log[i]);
    if (stall) chk(vcnt == WD_LIMIT, {rq, " R11 wait length"}, vcnt, WD_LIMIT);
    @(negedge clk);
    chk(!done && !ok && !io_err && !no_dev && !timeout, {rq, " R10 single pulse"}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(cmd_ready && !req_valid && !rsp_ready && !done, "R12 reset state", {cmd_ready, req_valid, rsp_ready, done}, 4'b1000);
    rst_n = 1;

    // R9 word read, R2 full width
    set_rsp(0, 4'h0, 32'hDEAD_BEEF, 0, 2'd3); run_txn(2'd3, 0, "R9 word");
    // R2 upper bits outside width excluded, R9 masking
    set_rsp(0, 4'h0, 32'hABCD_12F5, 0, 2'd1); run_txn(2'd1, 0, "R2 R9 byte");
    set_rsp(0, 4'h0, 32'h7777_8421, 0, 2'd2); run_txn(2'd2, 0, "R2 R9 half");
    // R2 no data fed for zero size
    set_rsp(0, 4'h0, 32'h1234_5678, 0, 2'd0); run_txn(2'd0, 0, "R2 zero size");
    // R1 upper tag bits ignored
    set_rsp(0, 4'hC, 32'h0000_00A5, 0, 2'd1); run_txn(2'd1, 0, "R1 upper tag");
    // R5 busy then ok
    set_rsp(0, 4'h1, 0, 0, 2'd3); set_rsp(1, 4'h1, 0, 0, 2'd3);
    set_rsp(2, 4'h0, 32'h0BAD_F00D, 0, 2'd3); run_txn(2'd3, 0, "R5 busy recovers");
    // R5 stuck busy -> terminate
    for (int i = 0; i < 4; i++) set_rsp(i, 4'h1, 0, 0, 2'd3);
    set_rsp(4, 4'h0, 0, 0, 2'd3); run_txn(2'd3, 0, "R5 stuck busy");
    // R4 R8 crc error then ok
    set_rsp(0, 4'h0, 32'h55, 1, 2'd1); set_rsp(1, 4'h0, 32'h66, 0, 2'd1);
    run_txn(2'd1, 0, "R4 R8 crc recover");
    // R4 limit
    for (int i = 0; i < 3; i++) set_rsp(i, 4'h1, 0, 1, 2'd2);
    run_txn(2'd2, 0, "R4 crc limit");
    // R3 dead link
    set_rsp(0, 0, 32'h1, 2, 2'd3); run_txn(2'd3, 0, "R3 all ones");
    set_rsp(0, 0, 32'h0, 3, 2'd0); run_txn(2'd0, 0, "R3 all zeros");
    // R6 hard error
    set_rsp(0, 4'h2, 0, 0, 2'd3); run_txn(2'd3, 0, "R6 hard");
    // R7 soft error retry and limit
    set_rsp(0, 4'h3, 0, 0, 2'd3); set_rsp(1, 4'h1, 0, 0, 2'd3);
    set_rsp(2, 4'h0, 32'hCAFE_0001, 0, 2'd3); run_txn(2'd3, 0, "R7 soft recover");
    for (int i = 0; i < 3; i++) set_rsp(i, 4'h3, 0, 0, 2'd1);
    run_txn(2'd1, 0, "R7 soft limit");
    // R11 stalled sender
    run_txn(2'd3, 1, "R11 timeout");

    // constrained random mix, R10 on every transaction
    for (int t = 0; t < 150; t++) begin
      logic [1:0] sz = 2'($urandom_range(3));
      for (int i = 0; i < SCN; i++) begin
        int r = $urandom_range(99);
        logic [3:0] up = 4'($urandom_range(3)) << 2;
        if (r < 30)      set_rsp(i, up | 4'h0, $urandom, 0, sz);
        else if (r < 60) set_rsp(i, up | 4'h1, $urandom, 0, sz);
        else if (r < 67) set_rsp(i, up | 4'h2, $urandom, 0, sz);
        else if (r < 80) set_rsp(i, up | 4'h3, $urandom, 0, sz);
        else if (r < 97) set_rsp(i, 4'($urandom), $urandom, 1, sz);
        else             set_rsp(i, 0, $urandom, 2 + (r & 1), sz);
      end
      run_txn(sz, 0, "R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule